// File: doc/BRIEF.md
# SMRAM Access Decode Guard

This block sits in the memory path and decides, for each access, where the access goes and whether it may proceed at all. The decision depends on the access address and on whether the processor is currently in system management mode (SMM). Two protections are combined. The first is a fixed legacy window covering 0xA0000 through 0xBFFFF, governed by a window control register that holds an open bit and a lock bit. The second is a programmable protected range, defined by a base register and a mask register with a valid bit, that guards the main system management memory.

Outside SMM, the legacy window is steered to the system bus unless software has opened it. A protected-range hit outside SMM is refused and marked uncacheable. When an access is refused, a read returns all ones, a write is dropped, and a sticky violation flag is raised. Setting the lock bit freezes the window control register for the rest of the run, so the window cannot be reopened until reset.

All access outputs are combinational from the access inputs and the stored configuration. Configuration writes and the violation flag take effect at the next clock edge.

Top module: `smram_guard`

## Requirements
- R1: After reset the window is closed and unlocked, the protected range is invalid and the violation flag is 0.
- R2: With the open bit at 0, a non-SMM access to any address from 0xA0000 to 0xBFFFF has route_dram = 0 (system bus). An SMM access there has route_dram = 1. Addresses just outside the window (0x9FFFF, 0xC0000) have route_dram = 1.
- R3: A window control write with bit 6 set opens the window. Non-SMM window accesses then have route_dram = 1.
- R4: A window control write with bit 4 set locks the window. The same write forces the open bit to 0. Every later window control write is ignored, so the window stays closed and locked until reset.
- R5: The range base register keeps address bits 31..12. The range mask register keeps mask bits 31..12, and bit 11 of the mask register is the valid bit. When valid, an address hits if ((addr XOR base) AND mask) is zero over bits 31..12. Bits 11..0 of the base are not compared.
- R6: A non-SMM hit on a valid range asserts acc_block and force_uc and gives route_dram = 0. An SMM hit is not blocked, has force_uc = 0 and route_dram = 1.
- R7: With the valid bit at 0, the range blocks nothing.
- R8: A blocked read returns all ones on acc_rdata. An unblocked read passes mem_rdata through. A blocked write gives mem_we = 0, and an unblocked write gives mem_we = 1.
- R9: The violation flag is set at the clock edge after a blocked access and stays set until reset.
- R10: A range hit outside SMM is blocked even when the address lies in an opened legacy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 window control, 1 range base, 2 range mask |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_smm | input | 1 | Processor is in SMM |
| acc_write | input | 1 | Access is a write (0 = read) |
| mem_rdata | input | 32 | Read data returned by the selected target |
| route_dram | output | 1 | 1 = send to DRAM, 0 = send to system bus |
| acc_block | output | 1 | Access is refused |
| force_uc | output | 1 | Access must be treated as uncacheable |
| mem_we | output | 1 | Write is allowed to proceed |
| acc_rdata | output | 32 | Read data to the requester |
| viol_flag | output | 1 | Sticky protection-violation indication |

## Verification
The bench builds the block with its default parameters. These are a 32-bit address and data path, a 4 KiB range granularity and the fixed 0xA0000–0xBFFFF window. With these values, the mask compare reaches the top address bits, so the range boundaries can be probed at 0xBD000000, 0xBD7FFFFC and 0xBD800000. The window edges are probed at 0x9FFFF and 0xC0000. Because only reset clears the lock bit, each scenario that needs an unlocked window starts with its own reset. This keeps the one-way lock transition reachable in isolation, together with the forced-closed open bit that comes with it.

// File: rtl/smram_pkg.sv
`timescale 1ns/1ps
package smram_pkg;

    localparam int WIN_LOCK_BIT  = 4;
    localparam int WIN_OPEN_BIT  = 6;
    localparam int RMASK_VLD_BIT = 11;

    typedef enum logic [1:0] {
        SEL_WIN   = 2'd0,
        SEL_RBASE = 2'd1,
        SEL_RMASK = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        ROUTE_BUS  = 1'b0,
        ROUTE_DRAM = 1'b1
    } route_e;

    typedef struct packed {
        logic lock;
        logic open;
    } win_ctrl_t;

    // Next window control state: frozen once locked; locking closes the window.
    function automatic win_ctrl_t win_next(win_ctrl_t cur, logic lock_in, logic open_in);
        win_ctrl_t n;
        if (cur.lock) begin
            n = cur;
        end else begin
            n.lock = lock_in;
            n.open = lock_in ? 1'b0 : open_in;
        end
        return n;
    endfunction

endpackage

// File: rtl/smram_cfg.sv
`timescale 1ns/1ps
module smram_cfg
    import smram_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int RANGE_LSB = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [1:0]                cfg_sel,
    input  logic [ADDR_W-1:0]         cfg_wdata,
    output win_ctrl_t                 win_q,
    output logic [ADDR_W-1:RANGE_LSB] rbase_q,
    output logic [ADDR_W-1:RANGE_LSB] rmask_q,
    output logic                      rvalid_q
);

    cfg_sel_e sel;
    logic     unused_cfg_bits;

    assign sel = cfg_sel_e'(cfg_sel);
    assign unused_cfg_bits = ^{cfg_wdata[RMASK_VLD_BIT-1:WIN_OPEN_BIT+1],
                               cfg_wdata[WIN_OPEN_BIT-1:WIN_LOCK_BIT+1],
                               cfg_wdata[WIN_LOCK_BIT-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q    <= '0;
            rbase_q  <= '0;
            rmask_q  <= '0;
            rvalid_q <= 1'b0;
        end else if (cfg_we) begin
            unique case (sel)
                SEL_WIN:   win_q <= win_next(win_q, cfg_wdata[WIN_LOCK_BIT],
                                             cfg_wdata[WIN_OPEN_BIT]);
                SEL_RBASE: rbase_q <= cfg_wdata[ADDR_W-1:RANGE_LSB];
                SEL_RMASK: begin
                    rmask_q  <= cfg_wdata[ADDR_W-1:RANGE_LSB];
                    rvalid_q <= cfg_wdata[RMASK_VLD_BIT];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/smram_range_match.sv
`timescale 1ns/1ps
module smram_range_match #(
    parameter int ADDR_W    = 32,
    parameter int RANGE_LSB = 12
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ADDR_W-1:RANGE_LSB] base,
    input  logic [ADDR_W-1:RANGE_LSB] mask,
    input  logic                      valid,
    output logic                      hit
);

    localparam int CMP_W = ADDR_W - RANGE_LSB;

    logic [CMP_W-1:0] diff;
    logic             unused_low_addr;

    assign unused_low_addr = ^addr[RANGE_LSB-1:0];

    for (genvar i = 0; i < CMP_W; i++) begin : g_bit
        assign diff[i] = (addr[RANGE_LSB+i] ^ base[RANGE_LSB+i]) & mask[RANGE_LSB+i];
    end

    assign hit = valid & ~(|diff);

endmodule

// File: rtl/smram_window_decode.sv
`timescale 1ns/1ps
module smram_window_decode #(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] WIN_LO = 32'h000A_0000,
    parameter logic [31:0] WIN_HI = 32'h000B_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win
);

    localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_LO);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(WIN_HI);

    assign in_win = (addr >= LO) && (addr <= HI);

endmodule

// File: rtl/smram_guard.sv
`timescale 1ns/1ps
module smram_guard
    import smram_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          RANGE_LSB = 12,
    parameter logic [31:0] WIN_LO    = 32'h000A_0000,
    parameter logic [31:0] WIN_HI    = 32'h000B_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    input  logic              acc_write,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              route_dram,
    output logic              acc_block,
    output logic              force_uc,
    output logic              mem_we,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              viol_flag
);

    win_ctrl_t                 win_q;
    logic [ADDR_W-1:RANGE_LSB] rbase_q;
    logic [ADDR_W-1:RANGE_LSB] rmask_q;
    logic                      rvalid_q;
    logic                      range_hit;
    logic                      in_win;
    logic                      win_lock;
    logic                      win_open;
    route_e                    route;

    assign win_lock = win_q.lock;
    assign win_open = win_q.open;

    smram_cfg #(.ADDR_W(ADDR_W), .RANGE_LSB(RANGE_LSB)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .win_q    (win_q),
        .rbase_q  (rbase_q),
        .rmask_q  (rmask_q),
        .rvalid_q (rvalid_q)
    );

    smram_range_match #(.ADDR_W(ADDR_W), .RANGE_LSB(RANGE_LSB)) u_range (
        .addr (acc_addr),
        .base (rbase_q),
        .mask (rmask_q),
        .valid(rvalid_q),
        .hit  (range_hit)
    );

    smram_window_decode #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
        .addr  (acc_addr),
        .in_win(in_win)
    );

    always_comb begin
        acc_block = acc_valid & range_hit & ~acc_smm;
        force_uc  = acc_valid & range_hit & ~acc_smm;
        if (acc_block)
            route = ROUTE_BUS;
        else if (in_win && !acc_smm && !win_q.open)
            route = ROUTE_BUS;
        else
            route = ROUTE_DRAM;
        route_dram = acc_valid & (route == ROUTE_DRAM);
        mem_we     = acc_valid & acc_write & ~acc_block;
        acc_rdata  = (acc_block && !acc_write) ? '1 : mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            viol_flag <= 1'b0;
        else if (acc_block)
            viol_flag <= 1'b1;
    end

endmodule

// File: rtl/smram_guard_chk.sv
`timescale 1ns/1ps
module smram_guard_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_smm,
    input logic              acc_write,
    input logic              acc_block,
    input logic              force_uc,
    input logic              route_dram,
    input logic              mem_we,
    input logic [DATA_W-1:0] acc_rdata,
    input logic              viol_flag,
    input logic              win_lock,
    input logic              win_open,
    input logic              in_win
);

    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        win_lock |=> win_lock);

    p_locked_closed_r4: assert property (@(posedge clk) disable iff (rst)
        win_lock |-> !win_open);

    p_block_not_smm_r6: assert property (@(posedge clk) disable iff (rst)
        acc_block |-> (!acc_smm && force_uc && !route_dram));

    p_window_bus_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && in_win && !acc_smm && !win_open) |-> !route_dram);

    p_rd_ones_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_block && !acc_write) |-> (acc_rdata == {DATA_W{1'b1}}));

    p_wr_drop_r8: assert property (@(posedge clk) disable iff (rst)
        acc_block |-> !mem_we);

    p_viol_set_r9: assert property (@(posedge clk) disable iff (rst)
        acc_block |=> viol_flag);

    p_viol_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        viol_flag |=> viol_flag);

endmodule

bind smram_guard smram_guard_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_smm   (acc_smm),
    .acc_write (acc_write),
    .acc_block (acc_block),
    .force_uc  (force_uc),
    .route_dram(route_dram),
    .mem_we    (mem_we),
    .acc_rdata (acc_rdata),
    .viol_flag (viol_flag),
    .win_lock  (win_lock),
    .win_open  (win_open),
    .in_win    (in_win)
);

// File: tb/tb_smram_guard.sv
`timescale 1ns/1ps
module tb_smram_guard;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic        acc_smm;
    logic        acc_write;
    logic [31:0] mem_rdata;
    logic        route_dram;
    logic        acc_block;
    logic        force_uc;
    logic        mem_we;
    logic [31:0] acc_rdata;
    logic        viol_flag;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [31:0] RD_PATTERN = 32'hCAFE_F00D;

    always #2 clk = ~clk;

    smram_guard dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_smm(acc_smm),
        .acc_write(acc_write), .mem_rdata(mem_rdata), .route_dram(route_dram),
        .acc_block(acc_block), .force_uc(force_uc), .mem_we(mem_we),
        .acc_rdata(acc_rdata), .viol_flag(viol_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = 2'd3; cfg_wdata = '0;
        acc_valid = 1'b0; acc_addr = '0; acc_smm = 1'b0; acc_write = 1'b0;
        mem_rdata = RD_PATTERN;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        acc_valid = 1'b0;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd3;
    endtask

    // Present an access in the low clock phase; outputs settle combinationally.
    task automatic access(input logic [31:0] addr, input logic smm, input logic wr);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = addr; acc_smm = smm; acc_write = wr;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 viol after reset", 32'(viol_flag), 0);
        access(32'h000A_0000, 1'b0, 1'b0);
        check("R1 window closed after reset", 32'(route_dram), 0);
        access(32'hBD00_0000, 1'b0, 1'b0);
        check("R1 range invalid after reset", 32'(acc_block), 0);
        idle();
        @(negedge clk);
        check("R1 viol stays 0", 32'(viol_flag), 0);
    endtask

    task automatic t_window_closed();
        do_reset();
        access(32'h000A_0000, 1'b0, 1'b0);
        check("R2 low edge non-SMM to bus", 32'(route_dram), 0);
        access(32'h000B_FFFF, 1'b0, 1'b1);
        check("R2 high edge non-SMM to bus", 32'(route_dram), 0);
        access(32'h000A_8000, 1'b1, 1'b0);
        check("R2 SMM to DRAM", 32'(route_dram), 1);
        access(32'h0009_FFFF, 1'b0, 1'b0);
        check("R2 below window to DRAM", 32'(route_dram), 1);
        access(32'h000C_0000, 1'b0, 1'b0);
        check("R2 above window to DRAM", 32'(route_dram), 1);
        idle();
    endtask

    task automatic t_window_open();
        do_reset();
        cfg_write(2'd0, 32'h0000_0040);
        access(32'h000B_0000, 1'b0, 1'b0);
        check("R3 opened window non-SMM to DRAM", 32'(route_dram), 1);
        access(32'h000B_0000, 1'b1, 1'b0);
        check("R3 opened window SMM to DRAM", 32'(route_dram), 1);
        idle();
    endtask

    task automatic t_lock();
        do_reset();
        cfg_write(2'd0, 32'h0000_0040);
        cfg_write(2'd0, 32'h0000_0050);
        access(32'h000A_0000, 1'b0, 1'b0);
        check("R4 lock forces closed", 32'(route_dram), 0);
        cfg_write(2'd0, 32'h0000_0040);
        access(32'h000A_0000, 1'b0, 1'b0);
        check("R4 open write ignored once locked", 32'(route_dram), 0);
        cfg_write(2'd0, 32'h0000_0000);
        cfg_write(2'd0, 32'h0000_0040);
        access(32'h000A_0000, 1'b0, 1'b0);
        check("R4 lock cannot be cleared", 32'(route_dram), 0);
        idle();
    endtask

    task automatic t_range();
        do_reset();
        cfg_write(2'd1, 32'hBD00_0006);
        cfg_write(2'd2, 32'hFF80_0800);
        access(32'hBD00_0000, 1'b0, 1'b0);
        check("R6 base hit blocked", 32'(acc_block), 1);
        check("R6 base hit uncacheable", 32'(force_uc), 1);
        check("R6 base hit not to DRAM", 32'(route_dram), 0);
        access(32'hBD7F_FFFC, 1'b0, 1'b0);
        check("R5 top of range hit", 32'(acc_block), 1);
        access(32'hBD80_0000, 1'b0, 1'b0);
        check("R5 past range no hit", 32'(acc_block), 0);
        check("R5 past range uc", 32'(force_uc), 0);
        access(32'hBCFF_F000, 1'b0, 1'b0);
        check("R5 below range no hit", 32'(acc_block), 0);
        access(32'hBD00_1000, 1'b1, 1'b0);
        check("R6 SMM not blocked", 32'(acc_block), 0);
        check("R6 SMM not uc", 32'(force_uc), 0);
        check("R6 SMM to DRAM", 32'(route_dram), 1);
        idle();
    endtask

    task automatic t_range_invalid();
        do_reset();
        cfg_write(2'd1, 32'hBD00_0000);
        cfg_write(2'd2, 32'hFF80_0000);
        access(32'hBD00_0000, 1'b0, 1'b0);
        check("R7 invalid range not blocked", 32'(acc_block), 0);
        check("R7 invalid range to DRAM", 32'(route_dram), 1);
        idle();
        @(negedge clk);
        check("R7 no violation", 32'(viol_flag), 0);
    endtask

    task automatic t_blocked_data();
        do_reset();
        cfg_write(2'd1, 32'hBD00_0000);
        cfg_write(2'd2, 32'hFF80_0800);
        access(32'hBD00_0040, 1'b0, 1'b0);
        check("R8 blocked read ones", acc_rdata, 32'hFFFF_FFFF);
        access(32'h1000_0040, 1'b0, 1'b0);
        check("R8 unblocked read passes", acc_rdata, RD_PATTERN);
        access(32'hBD00_0040, 1'b0, 1'b1);
        check("R8 blocked write dropped", 32'(mem_we), 0);
        access(32'hBD00_0040, 1'b1, 1'b1);
        check("R8 SMM write proceeds", 32'(mem_we), 1);
        check("R8 SMM read data passes", acc_rdata, RD_PATTERN);
        idle();
    endtask

    task automatic t_violation();
        do_reset();
        cfg_write(2'd1, 32'hBD00_0000);
        cfg_write(2'd2, 32'hFF80_0800);
        access(32'h2000_0000, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 no flag on clean access", 32'(viol_flag), 0);
        access(32'hBD00_0100, 1'b0, 1'b1);
        check("R9 flag not yet set before edge", 32'(viol_flag), 0);
        access(32'h2000_0000, 1'b0, 1'b0);
        check("R9 flag set after edge", 32'(viol_flag), 1);
        idle();
        @(negedge clk);
        @(negedge clk);
        check("R9 flag sticky", 32'(viol_flag), 1);
        do_reset();
        check("R9 flag cleared by reset", 32'(viol_flag), 0);
    endtask

    task automatic t_priority();
        do_reset();
        cfg_write(2'd0, 32'h0000_0040);
        cfg_write(2'd1, 32'h000A_0000);
        cfg_write(2'd2, 32'hFFFE_0800);
        access(32'h000A_4000, 1'b0, 1'b0);
        check("R10 range wins over open window", 32'(acc_block), 1);
        check("R10 not routed to DRAM", 32'(route_dram), 0);
        access(32'h000A_4000, 1'b1, 1'b0);
        check("R10 SMM allowed", 32'(route_dram), 1);
        idle();
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = 2'd3; cfg_wdata = '0;
        acc_valid = 1'b0; acc_addr = '0; acc_smm = 1'b0; acc_write = 1'b0;
        mem_rdata = RD_PATTERN;
        fork
            begin
                t_reset_state();
                t_window_closed();
                t_window_open();
                t_lock();
                t_range();
                t_range_invalid();
                t_blocked_data();
                t_violation();
                t_priority();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule